// File: doc/BRIEF.md
# Store-Conditional Reservation Tracker

This block holds the load-reserve / store-conditional reservation of one core. A load-reserve that completes without error arms the reservation and records its address, rounded down to the reservation granule. A store-conditional consumes the reservation. Its outcome is success, failed or bus error, and it feeds the condition-code update of the core.

There are two interfaces. On the issue side, the sequencer presents each new transfer. The block says whether the transfer may go out on the bus. A store-conditional with no live reservation is held back and fails at once. On the response side, the termination signals arrive: acknowledge, error and the external exclusive-failure flag. The flag may come from local reservation logic or from a failed exclusive response on the system bus. The block qualifies that flag by transfer type and by the error response. It then presents a 2-bit outcome for one cycle, together with a strobe.

Top module: `rsv_tracker`

## Requirements
- R1: After reset, `rsv_valid` is 0 and `res_valid` is 0.
- R2: A response with `rsp_kind` = 01 (load-reserve), `rsp_ack` = 1 and `rsp_err` = 0 sets `rsv_valid` after the next clock edge. `rsv_addr` then holds `rsp_addr` with its low GRAN_LG bits (3 by default) cleared.
- R3: A load-reserve response with `rsp_err` = 1 leaves the reservation flag and address unchanged.
- R4: A response with `rsp_kind` = 10 (store-conditional), `rsp_ack` = 1, `rsp_err` = 0 and `rsp_xfail` = 0 gives `res_code` = 00 (success) with `res_valid` after the next edge.
- R5: A store-conditional response with `rsp_ack` = 1, `rsp_xfail` = 1 and `rsp_err` = 0 gives `res_code` = 01 (failed). No error is reported.
- R6: A store-conditional response with `rsp_err` = 1 gives `res_code` = 10 (bus error), whatever the value of `rsp_xfail`.
- R7: `rsp_xfail` is ignored for kinds 00, 01 and 11. Such responses give no outcome, and a load-reserve with `rsp_xfail` = 1 still sets the reservation.
- R8: Every completed store-conditional (`rsp_ack` or `rsp_err`) clears `rsv_valid` after the next edge, whatever its outcome.
- R9: Issuing a store-conditional (`iss_kind` = 10) while `rsv_valid` = 0 holds `bus_go` at 0 in the same cycle. It then gives `res_code` = 01 with `res_valid` after the next edge.
- R10: Issuing any transfer while the reservation is valid, or any kind other than 10, drives `bus_go` to 1 combinationally and gives no outcome.
- R11: `res_valid` lasts one cycle per outcome, and `res_code` is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | New transfer presented for issue |
| iss_kind | input | 2 | Issue kind: 00 plain, 01 load-reserve, 10 store-conditional, 11 plain |
| bus_go | output | 1 | Transfer may be sent on the bus |
| rsp_kind | input | 2 | Kind of the terminating transfer, same encoding |
| rsp_addr | input | AW | Address of the terminating transfer |
| rsp_ack | input | 1 | Transfer acknowledge |
| rsp_err | input | 1 | Transfer error, takes priority over acknowledge |
| rsp_xfail | input | 1 | Exclusive store failure |
| rsv_valid | output | 1 | Reservation is live |
| rsv_addr | output | AW | Granule-aligned reserved address |
| res_valid | output | 1 | Outcome strobe |
| res_code | output | 2 | 00 success, 01 failed, 10 bus error |

## Verification
A stuck or wrongly set reservation flag shows up in the same cycle on `bus_go` when a later store-conditional is issued. A store-conditional that should go out is then held back, or one that should fail is sent. A missed clear after a completed store-conditional shows up at `rsv_valid` one edge later. A wrong qualification of the exclusive-failure or error input shows up as a wrong or spurious `res_code` strobe one edge after the response. The bench therefore probes the flag through both `rsv_valid` and the issue decision.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_LR    = 2'b01,
    KIND_SC    = 2'b10,
    KIND_PLN2  = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    OUT_OK   = 2'b00,
    OUT_FAIL = 2'b01,
    OUT_BERR = 2'b10
  } sc_out_e;
endpackage

// File: rtl/rsv_qualify.sv
module rsv_qualify
  import rsv_pkg::*;
(
  input  logic       iss_valid,
  input  logic [1:0] iss_kind,
  input  logic [1:0] rsp_kind,
  input  logic       rsp_ack,
  input  logic       rsp_err,
  input  logic       rsp_xfail,
  input  logic       rsv_live,
  output logic       bus_go,
  output logic       lr_set,
  output logic       sc_clear,
  output logic       out_fire,
  output logic [1:0] out_code
);
  logic sc_done;
  logic local_fail;

  always_comb begin
    sc_done    = (rsp_kind == KIND_SC) && (rsp_ack || rsp_err);
    lr_set     = (rsp_kind == KIND_LR) && rsp_ack && !rsp_err;
    local_fail = iss_valid && (iss_kind == KIND_SC) && !rsv_live;
    bus_go     = iss_valid && !local_fail;
    sc_clear   = sc_done;
    out_fire   = sc_done || local_fail;
    if (sc_done && rsp_err)        out_code = OUT_BERR;
    else if (sc_done && rsp_xfail) out_code = OUT_FAIL;
    else if (sc_done)              out_code = OUT_OK;
    else                           out_code = OUT_FAIL;
  end

  // R9
  always_comb begin
    local_fail_chk: assert (!(iss_valid && iss_kind == KIND_SC && !rsv_live) || !bus_go);
  end
endmodule

// File: rtl/rsv_hold.sv
module rsv_hold #(
  parameter int AW      = 32,
  parameter int GRAN_LG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [AW-1:0] set_addr,
  output logic          valid_q,
  output logic [AW-1:0] addr_q
);
  localparam logic [AW-1:0] GMASK = ~((AW'(1) << GRAN_LG) - AW'(1));

  logic          valid_d;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    valid_d = valid_q;
    addr_en = set;
    addr_d  = set_addr & GMASK;
    if (clr)      valid_d = 1'b0;
    else if (set) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R8
  sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !valid_q);
  // R2
  lr_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (set && !clr) |=> valid_q);
endmodule

// File: rtl/rsv_outreg.sv
module rsv_outreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] code,
  output logic       res_valid,
  output logic [1:0] res_code
);
  logic       vld_d;
  logic [1:0] code_d;

  always_comb begin
    vld_d  = fire;
    code_d = fire ? code : res_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= 2'b00;
    end else begin
      res_valid <= vld_d;
      res_code  <= code_d;
    end
  end

  // R11
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> (res_code != 2'b11));
  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !fire |=> !res_valid);
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
  import rsv_pkg::*;
#(
  parameter int AW      = 32,
  parameter int GRAN_LG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_kind,
  output logic          bus_go,
  input  logic [1:0]    rsp_kind,
  input  logic [AW-1:0] rsp_addr,
  input  logic          rsp_ack,
  input  logic          rsp_err,
  input  logic          rsp_xfail,
  output logic          rsv_valid,
  output logic [AW-1:0] rsv_addr,
  output logic          res_valid,
  output logic [1:0]    res_code
);
  logic       lr_set;
  logic       sc_clear;
  logic       out_fire;
  logic [1:0] out_code;

  rsv_qualify u_qual (
    .iss_valid (iss_valid),
    .iss_kind  (iss_kind),
    .rsp_kind  (rsp_kind),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err),
    .rsp_xfail (rsp_xfail),
    .rsv_live  (rsv_valid),
    .bus_go    (bus_go),
    .lr_set    (lr_set),
    .sc_clear  (sc_clear),
    .out_fire  (out_fire),
    .out_code  (out_code)
  );

  rsv_hold #(.AW(AW), .GRAN_LG(GRAN_LG)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (lr_set),
    .clr      (sc_clear),
    .set_addr (rsp_addr),
    .valid_q  (rsv_valid),
    .addr_q   (rsv_addr)
  );

  rsv_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (out_fire),
    .code      (out_code),
    .res_valid (res_valid),
    .res_code  (res_code)
  );

  // R6
  berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == KIND_SC && rsp_err) |=> (res_valid && res_code == OUT_BERR));
  // R7
  xfail_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind != KIND_SC && !(iss_valid && iss_kind == KIND_SC && !rsv_valid)) |=> !res_valid);
  // R5
  xfail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == KIND_SC && rsp_ack && rsp_xfail && !rsp_err) |=> (res_code == OUT_FAIL));
endmodule

// File: tb/sim_rsv_tracker.sv
`timescale 1ns/1ps
module sim_rsv_tracker;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid;
  logic [1:0]    iss_kind;
  logic          bus_go;
  logic [1:0]    rsp_kind;
  logic [AW-1:0] rsp_addr;
  logic          rsp_ack, rsp_err, rsp_xfail;
  logic          rsv_valid;
  logic [AW-1:0] rsv_addr;
  logic          res_valid;
  logic [1:0]    res_code;

  int compared = 0;
  int mismatched = 0;
  logic [1:0] expq[$];
  string      tagq[$];
  bit         mon_on = 1'b0;

  always #10 clk = ~clk;

  rsv_tracker #(.AW(AW), .GRAN_LG(3)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .bus_go(bus_go), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rsp_ack(rsp_ack),
    .rsp_err(rsp_err), .rsp_xfail(rsp_xfail), .rsv_valid(rsv_valid),
    .rsv_addr(rsv_addr), .res_valid(res_valid), .res_code(res_code)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected outcomes as strobes appear
  always @(posedge clk) begin
    #1;
    if (mon_on && res_valid) begin
      compared++;
      if (expq.size() == 0) begin
        mismatched++;
        $display("FAIL R7 unexpected outcome actual=%0h expected=none", res_code);
      end else begin
        logic [1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (res_code !== e) begin
          mismatched++;
          $display("FAIL %s outcome actual=%0h expected=%0h", t, res_code, e);
        end
      end
    end
  end

  task automatic idle();
    iss_valid = 0; iss_kind = 2'b00; rsp_kind = 2'b00; rsp_addr = '0;
    rsp_ack = 0; rsp_err = 0; rsp_xfail = 0;
  endtask

  // driver: one response cycle, pushes the expected outcome
  task automatic respond(logic [1:0] k, logic [AW-1:0] a, logic ack, logic err,
                         logic xf, bit has_out, logic [1:0] e, string t);
    @(negedge clk);
    idle();
    rsp_kind = k; rsp_addr = a; rsp_ack = ack; rsp_err = err; rsp_xfail = xf;
    if (has_out) begin expq.push_back(e); tagq.push_back(t); end
    @(negedge clk);
    idle();
  endtask

  task automatic issue(logic [1:0] k, logic exp_go, bit has_out, string t);
    @(negedge clk);
    idle();
    iss_valid = 1; iss_kind = k;
    #1 chk({t, " bus_go"}, bus_go, exp_go);
    if (has_out) begin expq.push_back(2'b01); tagq.push_back(t); end
    @(negedge clk);
    idle();
  endtask

  initial begin
    #3_000_000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 rsv_valid", rsv_valid, 0);
    chk("R1 res_valid", res_valid, 0);
    rst_n = 1;
    mon_on = 1;
    @(negedge clk);

    // R9: SC with no reservation fails locally
    issue(2'b10, 0, 1, "R9");
    // R10: plain issue goes
    issue(2'b00, 1, 0, "R10");
    // R2: LR arms, aligned
    respond(2'b01, 32'h1234_567D, 1, 0, 0, 0, 2'b00, "R2");
    chk("R2 rsv_valid", rsv_valid, 1);
    chk("R2 rsv_addr", rsv_addr, 32'h1234_5678);
    // R10: SC issue with reservation goes
    issue(2'b10, 1, 0, "R10");
    // R4: success and clear
    respond(2'b10, 32'h1234_5678, 1, 0, 0, 1, 2'b00, "R4");
    chk("R8 clear after ok", rsv_valid, 0);
    // R3: LR error leaves it clear
    respond(2'b01, 32'hAAAA_0000, 0, 1, 0, 0, 2'b00, "R3");
    chk("R3 rsv_valid", rsv_valid, 0);
    issue(2'b10, 0, 1, "R3");
    // R7: LR with xfail still arms
    respond(2'b01, 32'h0000_1007, 1, 0, 1, 0, 2'b00, "R7");
    chk("R7 lr xfail arms", rsv_valid, 1);
    chk("R7 addr", rsv_addr, 32'h0000_1000);
    // R3: LR error keeps existing address
    respond(2'b01, 32'hFFFF_FFF0, 1, 1, 0, 0, 2'b00, "R3");
    chk("R3 keep valid", rsv_valid, 1);
    chk("R3 keep addr", rsv_addr, 32'h0000_1000);
    // R7: plain response with xfail, no outcome, reservation kept
    respond(2'b00, 32'h0, 1, 0, 1, 0, 2'b00, "R7");
    respond(2'b11, 32'h0, 1, 0, 1, 0, 2'b00, "R7");
    chk("R7 plain keeps", rsv_valid, 1);
    // R5: xfail fails and clears
    respond(2'b10, 32'h0000_1000, 1, 0, 1, 1, 2'b01, "R5");
    chk("R8 clear after fail", rsv_valid, 0);
    // R6: error with xfail
    respond(2'b01, 32'h0000_2000, 1, 0, 0, 0, 2'b00, "R6");
    respond(2'b10, 32'h0000_2000, 1, 1, 1, 1, 2'b10, "R6");
    chk("R8 clear after err", rsv_valid, 0);
    // R6: error without ack
    respond(2'b01, 32'h0000_3000, 1, 0, 0, 0, 2'b00, "R6");
    respond(2'b10, 32'h0000_3000, 0, 1, 0, 1, 2'b10, "R6");
    chk("R8 clear after err2", rsv_valid, 0);
    // R11: back-to-back outcomes then one-cycle strobe
    respond(2'b01, 32'h0000_4000, 1, 0, 0, 0, 2'b00, "R11");
    respond(2'b10, 32'h0000_4000, 1, 0, 0, 1, 2'b00, "R11");
    @(negedge clk);
    chk("R11 strobe drops", res_valid, 0);
    repeat (3) @(negedge clk);
    chk("R11 queue drained", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule